// File: doc/BRIEF.md
# Bit-Settable GPIO Port with Per-Pin Configuration

This block is a general-purpose I/O port of up to 32 pins behind a simple word-addressed register bus. Software drives each pin through an output value register, an output-enable (direction) register and a configuration word per pin. The output and direction registers both have write-one-to-set and write-one-to-clear aliases, so single bits change without a read-modify-write. The direction bit is kept in one place: it is visible as a bit of the port-wide direction register and as bit 0 of the pin's own configuration word, and a write to either changes the other.

Each pin sees an external input that may be actively driven high or low, or left floating. A held input register resolves the level every cycle from own-output loop-back, the external driver, the selected pull resistor, or the last held value. When a pin drives its output while an outside driver forces the opposite level, a sticky per-pin contention flag is raised and a port-wide error output goes high until software clears the flag.

Register map (word addresses): 0 output value, 1 output set, 2 output clear, 3 input, 4 direction, 5 direction set, 6 direction clear, 7 contention flags, 32+n configuration of pin n.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output, output-set, output-clear, input, direction, direction-set, direction-clear and contention registers read 0, each configuration word reads 0x2, and pad_out, pad_oe and short_err are 0.
- R2: A write to direction-set (word 5) sets the written-1 direction bits, a write to direction-clear (word 6) clears them, and a write to direction (word 4) replaces all bits; pins 0 and 31 obey this alike.
- R3: Configuration word layout: bit 0 direction (1 = output), bit 1 input disconnect (1 = disconnected), bits 3:2 pull (00 none, 01 down, 11 up, 10 none), upper bits read 0. Direction changes made through words 4 to 6 show in bit 0, and a configuration write changes the pin's bit in word 4.
- R4: The output register (word 0) is written directly or through set (word 1) and clear (word 2) masks; pad_out equals the output register and pad_oe equals the direction register, one cycle after the write.
- R5: With the input connected, no pull and direction input, the input bit takes the external level one cycle after it is driven, and keeps its last value while the external driver floats.
- R6: With pull up (0b1110) or pull down (0b0110) and the input disconnected or floating, the input bit reads the pulled level.
- R7: With direction output and input connected (0b01), the input bit reads the pin's own output value.
- R8: An output-enabled pin whose external driver forces the opposite level sets its bit in the contention register (word 7) on the next cycle and raises short_err; the bit stays set until 1 is written to it, and an ongoing contention wins over that clear.
- R9: Reads of the set and clear aliases (words 1, 2, 5, 6) return 0.
- R10: Reads of unmapped words (8 to 31, or configuration words above the pin count) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pad_in_drv | input | NPINS | 1 where an external driver is active on the pin |
| pad_in_val | input | NPINS | Level of the external driver |
| pad_out | output | NPINS | Output value per pin |
| pad_oe | output | NPINS | Output enable per pin |
| short_err | output | 1 | OR of all contention flags |

## Verification
The bench builds the port with its default of 32 pins and a 6-bit word address. That width places the configuration word of the last pin at the top address 63, so pin 31 and the far edge of the map are exercised together with pin 0, and the unmapped gap between the contention word and the first configuration word can be probed. All pin-level stimulus goes to pin 0 while the other 31 pins stay disconnected, so every full-word read of the input register also shows that those pins hold their reset value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_W = 32;

  // word addresses
  localparam int unsigned A_OUT      = 0;
  localparam int unsigned A_OUTSET   = 1;
  localparam int unsigned A_OUTCLR   = 2;
  localparam int unsigned A_IN       = 3;
  localparam int unsigned A_DIR      = 4;
  localparam int unsigned A_DIRSET   = 5;
  localparam int unsigned A_DIRCLR   = 6;
  localparam int unsigned A_ERR      = 7;
  localparam int unsigned A_CFG_BASE = 32;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_RSVD = 2'b10,
    PULL_UP   = 2'b11
  } pull_e;

  // configuration fields other than the shared direction bit
  typedef struct packed {
    pull_e pull;
    logic  disc;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, disc: 1'b1};

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  input  logic [NPINS-1:0]          in_vec,
  input  logic [NPINS-1:0]          err_vec,
  output logic [NPINS-1:0]          out_q,
  output logic [NPINS-1:0]          dir_q,
  output pin_cfg_t [NPINS-1:0]      cfg_q,
  output logic [NPINS-1:0]          err_clr
);

  localparam logic [ADDR_W-1:0] AD_OUT    = ADDR_W'(A_OUT);
  localparam logic [ADDR_W-1:0] AD_OUTSET = ADDR_W'(A_OUTSET);
  localparam logic [ADDR_W-1:0] AD_OUTCLR = ADDR_W'(A_OUTCLR);
  localparam logic [ADDR_W-1:0] AD_IN     = ADDR_W'(A_IN);
  localparam logic [ADDR_W-1:0] AD_DIR    = ADDR_W'(A_DIR);
  localparam logic [ADDR_W-1:0] AD_DIRSET = ADDR_W'(A_DIRSET);
  localparam logic [ADDR_W-1:0] AD_DIRCLR = ADDR_W'(A_DIRCLR);
  localparam logic [ADDR_W-1:0] AD_ERR    = ADDR_W'(A_ERR);

  logic [NPINS-1:0]     out_d;
  logic [NPINS-1:0]     dir_d;
  pin_cfg_t [NPINS-1:0] cfg_d;
  logic [NPINS-1:0]     wmask;

  assign wmask = bus_wdata[NPINS-1:0];

  // next-state
  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    cfg_d   = cfg_q;
    err_clr = '0;
    if (bus_wr) begin
      case (bus_addr)
        AD_OUT:    out_d = wmask;
        AD_OUTSET: out_d = out_q | wmask;
        AD_OUTCLR: out_d = out_q & ~wmask;
        AD_DIR:    dir_d = wmask;
        AD_DIRSET: dir_d = dir_q | wmask;
        AD_DIRCLR: dir_d = dir_q & ~wmask;
        AD_ERR:    err_clr = wmask;
        default: begin
          for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == ADDR_W'(A_CFG_BASE + i)) begin
              dir_d[i]      = bus_wdata[0];
              cfg_d[i].disc = bus_wdata[1];
              cfg_d[i].pull = pull_e'(bus_wdata[3:2]);
            end
          end
        end
      endcase
    end
  end

  // state, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      cfg_q <= {NPINS{CFG_RESET}};
    end else if (bus_wr) begin
      out_q <= out_d;
      dir_q <= dir_d;
      cfg_q <= cfg_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AD_OUT: bus_rdata[NPINS-1:0] = out_q;
      AD_IN:  bus_rdata[NPINS-1:0] = in_vec;
      AD_DIR: bus_rdata[NPINS-1:0] = dir_q;
      AD_ERR: bus_rdata[NPINS-1:0] = err_vec;
      default: begin
        for (int i = 0; i < NPINS; i++) begin
          if (bus_addr == ADDR_W'(A_CFG_BASE + i)) begin
            bus_rdata[3:0] = {cfg_q[i].pull, cfg_q[i].disc, dir_q[i]};
          end
        end
      end
    endcase
  end

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AD_OUTSET || bus_addr == AD_OUTCLR ||
     bus_addr == AD_DIRSET || bus_addr == AD_DIRCLR) |-> bus_rdata == '0); // R9

  AST_DIRSET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AD_DIRSET) |=>
      ((dir_q & $past(wmask)) == $past(wmask))); // R2

  AST_DIRCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AD_DIRCLR) |=> ((dir_q & $past(wmask)) == '0)); // R2

  AST_OUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(out_q) && $stable(dir_q)); // R4

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
  import gpio_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dir_en,
  input  pin_cfg_t cfg,
  input  logic     out_val,
  input  logic     ext_drv,
  input  logic     ext_val,
  input  logic     err_clr,
  output logic     in_q,
  output logic     err_q
);

  logic conn;
  logic in_d;
  logic err_d;
  logic clash;

  assign conn  = ~cfg.disc;
  assign clash = dir_en & ext_drv & (ext_val ^ out_val);

  // input resolution: loop-back, then external driver, then pull, else hold
  always_comb begin
    in_d = in_q;
    if (dir_en && conn) begin
      in_d = out_val;
    end else if (conn && ext_drv) begin
      in_d = ext_val;
    end else if (cfg.pull == PULL_UP) begin
      in_d = 1'b1;
    end else if (cfg.pull == PULL_DOWN) begin
      in_d = 1'b0;
    end
  end

  // contention flag: a new clash wins over a clear in the same cycle
  always_comb begin
    err_d = err_q;
    if (clash) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      in_q  <= in_d;
      err_q <= err_d;
    end
  end

  AST_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_en && !cfg.disc) |=> in_q == $past(out_val)); // R7

  AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_en && !(!cfg.disc && ext_drv) &&
     (cfg.pull == PULL_NONE || cfg.pull == PULL_RSVD)) |=> $stable(in_q)); // R5

  AST_PULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_en && cfg.disc && cfg.pull == PULL_UP) |=> in_q); // R6

  AST_CLASH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_en && ext_drv && (ext_val != out_val)) |=> err_q); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in_drv,
  input  logic [NPINS-1:0]  pad_in_val,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              short_err
);

  logic                 rst_sync_n;
  logic [NPINS-1:0]     out_q;
  logic [NPINS-1:0]     dir_q;
  pin_cfg_t [NPINS-1:0] cfg_q;
  logic [NPINS-1:0]     err_clr;
  logic [NPINS-1:0]     in_vec;
  logic [NPINS-1:0]     err_vec;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_port_regs #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_vec    (in_vec),
    .err_vec   (err_vec),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .cfg_q     (cfg_q),
    .err_clr   (err_clr)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_port_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .dir_en  (dir_q[g]),
      .cfg     (cfg_q[g]),
      .out_val (out_q[g]),
      .ext_drv (pad_in_drv[g]),
      .ext_val (pad_in_val[g]),
      .err_clr (err_clr[g]),
      .in_q    (in_vec[g]),
      .err_q   (err_vec[g])
    );
  end

  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
  assign short_err = |err_vec;

  AST_ERR_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_vec == '0) |-> !short_err); // R8

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

  localparam int NPINS  = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pad_in_drv;
  logic [NPINS-1:0]  pad_in_val;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_oe;
  logic              short_err;

  always #2 clk = ~clk;

  gpio_port #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_in_drv (pad_in_drv),
    .pad_in_val (pad_in_val),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .short_err  (short_err)
  );

  // scoreboard item kinds
  localparam int K_RD  = 0;
  localparam int K_OUT = 1;
  localparam int K_OE  = 2;
  localparam int K_ERR = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_OUT:   act = 32'(pad_out);
          K_OE:    act = 32'(pad_oe);
          default: act = {31'b0, short_err};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=0x%08h expected=0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = ADDR_W'(addr);
    bus_wdata = data;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic exp_rd(input int addr, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    bus_addr = ADDR_W'(addr);
    it.kind = K_RD; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic exp_pin(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic pad0(input logic drv, input logic val);
    @(negedge clk);
    pad_in_drv[0] = drv;
    pad_in_val[0] = val;
  endtask

  localparam int CFG0  = 32;
  localparam int CFG5  = 37;
  localparam int CFG31 = 63;

  initial begin
    rst_n      = 1'b0;
    bus_wr     = 1'b0;
    bus_addr   = '0;
    bus_wdata  = '0;
    pad_in_drv = '0;
    pad_in_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    exp_rd(0, 0, "R1 out");
    exp_rd(1, 0, "R1 outset");
    exp_rd(2, 0, "R1 outclr");
    exp_rd(3, 0, "R1 in");
    exp_rd(4, 0, "R1 dir");
    exp_rd(5, 0, "R1 dirset");
    exp_rd(6, 0, "R1 dirclr");
    exp_rd(7, 0, "R1 err");
    exp_rd(CFG0, 32'h2, "R1 cfg0");
    exp_rd(CFG31, 32'h2, "R1 cfg31");
    exp_pin(K_OUT, 0, "R1 pad_out");
    exp_pin(K_OE, 0, "R1 pad_oe");
    exp_pin(K_ERR, 0, "R1 short_err");

    // R2 / R3 direction aliases, pins 0 and 31
    wr(5, 32'h8000_0001);
    exp_rd(4, 32'h8000_0001, "R2 dirset");
    exp_rd(CFG0, 32'h3, "R3 cfg0 dir bit after set");
    exp_rd(CFG31, 32'h3, "R3 cfg31 dir bit after set");
    exp_rd(5, 0, "R9 dirset reads zero");
    exp_rd(6, 0, "R9 dirclr reads zero");
    wr(6, 32'h8000_0001);
    exp_rd(4, 0, "R2 dirclr");
    exp_rd(CFG0, 32'h2, "R3 cfg0 dir bit after clear");
    exp_rd(CFG31, 32'h2, "R3 cfg31 dir bit after clear");
    wr(4, 32'h8000_0001);
    exp_rd(4, 32'h8000_0001, "R2 direct dir write");
    exp_rd(CFG31, 32'h3, "R3 cfg31 after direct write");
    wr(4, 32'h0000_0010);
    exp_rd(4, 32'h0000_0010, "R2 direct write replaces");
    wr(5, 32'h0000_0001);
    exp_rd(4, 32'h0000_0011, "R2 dirset accumulates");
    wr(4, 0);
    wr(CFG5, 32'h1);
    exp_rd(4, 32'h0000_0020, "R3 cfg write sets dir");
    exp_rd(CFG5, 32'h1, "R3 cfg5 readback");
    wr(CFG5, 32'hFFFF_FFF2);
    exp_rd(CFG5, 32'h2, "R3 upper cfg bits read zero");
    exp_rd(4, 0, "R3 cfg write clears dir");

    // R10 unmapped
    exp_rd(16, 0, "R10 unmapped word");

    // R5 connected, no pull
    wr(CFG0, 32'h0);
    pad0(1'b1, 1'b0);
    exp_rd(3, 0, "R5 input low");
    pad0(1'b1, 1'b1);
    exp_rd(3, 1, "R5 input high");
    pad0(1'b0, 1'b1);
    exp_rd(3, 1, "R5 floating holds");

    // R6 pulls
    pad0(1'b1, 1'b0);
    exp_rd(3, 0, "R6 pre driven low");
    wr(CFG0, 32'hE);
    exp_rd(3, 1, "R6 pull-up disconnected");
    pad0(1'b0, 1'b0);
    exp_rd(3, 1, "R6 pull-up floating");
    wr(CFG0, 32'h0);
    pad0(1'b1, 1'b1);
    exp_rd(3, 1, "R6 pre driven high");
    wr(CFG0, 32'h6);
    exp_rd(3, 0, "R6 pull-down disconnected");
    wr(CFG0, 32'h2);
    pad0(1'b0, 1'b0);
    exp_rd(3, 0, "R6 disconnected holds");

    // R4 output path
    wr(CFG0, 32'h3);
    exp_pin(K_OE, 32'h1, "R4 pad_oe from cfg");
    wr(1, 32'h1);
    exp_pin(K_OUT, 32'h1, "R4 outset drives high");
    exp_rd(0, 32'h1, "R4 out after set");
    exp_rd(1, 0, "R9 outset reads zero");
    exp_rd(2, 0, "R9 outclr reads zero");
    wr(2, 32'h1);
    exp_pin(K_OUT, 0, "R4 outclr drives low");
    wr(0, 32'hA5);
    wr(2, 32'h5);
    exp_rd(0, 32'hA0, "R4 outclr mask");
    wr(1, 32'h100);
    exp_rd(0, 32'h1A0, "R4 outset mask");
    exp_pin(K_OUT, 32'h1A0, "R4 pad_out follows");
    wr(0, 0);

    // R7 loop-back
    wr(CFG0, 32'h1);
    wr(1, 32'h1);
    exp_rd(3, 1, "R7 loopback high");
    wr(2, 32'h1);
    exp_rd(3, 0, "R7 loopback low");

    // R8 contention
    wr(1, 32'h1);
    pad0(1'b1, 1'b0);
    exp_pin(K_ERR, 1, "R8 short_err raised");
    exp_rd(7, 1, "R8 flag set");
    exp_rd(3, 1, "R7 loopback under contention");
    pad0(1'b0, 1'b0);
    exp_rd(7, 1, "R8 sticky after release");
    wr(7, 0);
    exp_rd(7, 1, "R8 write zero keeps flag");
    wr(7, 1);
    exp_rd(7, 0, "R8 write one clears");
    exp_pin(K_ERR, 0, "R8 short_err cleared");
    pad0(1'b1, 1'b1);
    exp_rd(7, 0, "R8 matching level no error");
    pad0(1'b1, 1'b0);
    wr(7, 1);
    exp_rd(7, 1, "R8 ongoing clash beats clear");
    pad0(1'b0, 1'b0);
    wr(7, 1);
    exp_rd(7, 0, "R8 clear after release");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

endmodule